// File: doc/BRIEF.md
# Two-Phase Power-Gated Row Sequencer

This block sequences the supply of a 16-row, 2048-cell power-up-state array used as a hardware fingerprint source. A start strobe hands it a challenge: the low part selects the row that will be powered, and the high part selects which 8-bit word of that row's 128 bits is sent to the response output. Every other row stays unpowered for the whole evaluation.

For the selected row, each evaluation runs four timed stages. In ramp, only the weak phase-I supply enable is active. In boost, the strong phase-II enable joins it. In sense, the word line is raised while both supplies stay on. In drain, both supplies are switched off and the word line is dropped, so the cells discharge before anything else happens. The length of each stage is a programmable number of clock cycles. A repeat count runs the same challenge several times back to back, and every run ends with its own drain stage. The analog cells and the sensing are outside the block: the row's bits arrive on `row_bits`, and a column multiplexer driven by the latched word select picks the response word.

States: `ST_IDLE`, `ST_RAMP`, `ST_BOOST`, `ST_SENSE`, `ST_DRAIN`.

Transitions:
- `ST_IDLE`→`ST_RAMP` on start.
- `ST_RAMP`→`ST_BOOST`, `ST_BOOST`→`ST_SENSE` and `ST_SENSE`→`ST_DRAIN` when the stage timer expires.
- `ST_DRAIN`→`ST_RAMP` when the timer expires and runs remain.
- `ST_DRAIN`→`ST_IDLE` when the timer expires and the last run is done.
- Any state→`ST_IDLE` on synchronous reset.

Top module: `pgate_row_seq`

## Requirements
- R1: After reset, and whenever the block is idle, all `sup1_n` and `sup2_n` bits are 1, all `wl` bits are 0, `resp_valid` is 0 and `ready` is 1.
- R2: A start accepted in idle latches `challenge[3:0]` as the row index (bit i of the row vectors) and `challenge[7:4]` as `col_sel`. The ramp stage begins in the next cycle.
- R3: At most one row is ever powered. Only bit `row` of `sup1_n`, `sup2_n` and `wl` may leave its inactive level.
- R4: The ramp stage lasts `ramp_len` cycles, with a value of 0 treated as 1. During ramp, `sup1_n[row]`=0, `sup2_n[row]`=1 and `wl`=0.
- R5: The boost stage follows and lasts `boost_len` cycles, with 0 treated as 1. During boost, both enables of the row are 0 and `wl`=0.
- R6: The sense stage follows and lasts `sense_len` cycles, with 0 treated as 1. During sense, `wl[row]`=1 while both enables stay 0. The word line is never high unless both enables are low.
- R7: The drain stage follows and lasts `drain_len` cycles, with 0 treated as 1. During drain, both enables are 1 and `wl`=0.
- R8: `resp_valid` is high for exactly the last cycle of each sense stage. In that cycle, `resp` equals bits `[8*col_sel +: 8]` of `row_bits`.
- R9: A start raised while not idle has no effect: row, word select and timing continue unchanged.
- R10: Each accepted challenge is evaluated `repeat_len` times, with 0 treated as 1. The runs follow one another directly, each ending in a full drain stage, and the block returns to idle after the last drain.
- R11: Stage lengths and the repeat count are sampled when the start is accepted. Changes to these inputs during an evaluation have no effect on it.
- R12: A synchronous reset during any stage returns the block to the R1 state at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe, accepted only while idle |
| challenge | input | 8 | [3:0] row index, [7:4] word select |
| ramp_len | input | 8 | Phase-I-only stage length in cycles |
| boost_len | input | 8 | Both-supplies stage length in cycles |
| sense_len | input | 8 | Word-line stage length in cycles |
| drain_len | input | 8 | Discharge stage length in cycles |
| repeat_len | input | 8 | Number of evaluations per challenge |
| row_bits | input | 128 | Sensed bits of the powered row |
| sup1_n | output | 16 | Phase-I supply enable per row, active low |
| sup2_n | output | 16 | Phase-II supply enable per row, active low |
| wl | output | 16 | Word line per row, active high |
| col_sel | output | 4 | Latched word select |
| resp | output | 8 | Selected response word |
| resp_valid | output | 1 | Response strobe, one cycle per evaluation |
| ready | output | 1 | High when idle and able to accept a start |

## Verification
The bench compares every output on every cycle against a queue-based model. It goes after these corner cases:
- Stage lengths of zero. A design that decrements before testing would wrap to 255 and hang in one stage.
- Repeated evaluations. A design that skipped the drain between runs would keep the word line or supplies up across the boundary.
- Starts raised during a run. A design that accepted them would switch rows under a powered word line.
- Length inputs changed mid-run. A design that read them live would stretch or cut stages.
- Reset in the middle of sense. A design that reset only the state register would leave a row powered.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RAMP  = 3'd1,
        ST_BOOST = 3'd2,
        ST_SENSE = 3'd3,
        ST_DRAIN = 3'd4
    } seq_state_t;
endpackage

// File: rtl/stage_timer.sv
module stage_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/rowseq_ctrl.sv
module rowseq_ctrl
    import rowseq_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [ROW_W-1:0] ch_row,
    input  logic [COL_W-1:0] ch_col,
    input  logic [CNT_W-1:0] ramp_len,
    input  logic [CNT_W-1:0] boost_len,
    input  logic [CNT_W-1:0] sense_len,
    input  logic [CNT_W-1:0] drain_len,
    input  logic [CNT_W-1:0] repeat_len,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic [ROW_W-1:0] row_q,
    output logic [COL_W-1:0] col_q,
    output logic             en_ph1,
    output logic             en_ph2,
    output logic             en_wl,
    output logic             resp_valid,
    output logic             ready
);
    seq_state_t       state, nxt;
    logic [CNT_W-1:0] ramp_m1, boost_m1, sense_m1, drain_m1, reps_left;
    logic             accept, more_runs;

    function automatic logic [CNT_W-1:0] len_m1(input logic [CNT_W-1:0] x);
        return (x == '0) ? '0 : x - CNT_W'(1);
    endfunction

    assign accept    = (state == ST_IDLE) && start;
    assign more_runs = (reps_left > CNT_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // sampled challenge, lengths and repeat count
    always_ff @(posedge clk) begin
        if (rst) begin
            row_q     <= '0;
            col_q     <= '0;
            ramp_m1   <= '0;
            boost_m1  <= '0;
            sense_m1  <= '0;
            drain_m1  <= '0;
            reps_left <= '0;
        end else if (accept) begin
            row_q     <= ch_row;
            col_q     <= ch_col;
            ramp_m1   <= len_m1(ramp_len);
            boost_m1  <= len_m1(boost_len);
            sense_m1  <= len_m1(sense_len);
            drain_m1  <= len_m1(drain_len);
            reps_left <= (repeat_len == '0) ? CNT_W'(1) : repeat_len;
        end else if (state == ST_DRAIN && tmr_done && more_runs) begin
            reps_left <= reps_left - CNT_W'(1);
        end
    end

    // next state and timer load
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: if (start) begin
                nxt = ST_RAMP; tmr_load = 1'b1; tmr_val = len_m1(ramp_len);
            end
            ST_RAMP: if (tmr_done) begin
                nxt = ST_BOOST; tmr_load = 1'b1; tmr_val = boost_m1;
            end
            ST_BOOST: if (tmr_done) begin
                nxt = ST_SENSE; tmr_load = 1'b1; tmr_val = sense_m1;
            end
            ST_SENSE: if (tmr_done) begin
                nxt = ST_DRAIN; tmr_load = 1'b1; tmr_val = drain_m1;
            end
            ST_DRAIN: if (tmr_done) begin
                if (more_runs) begin
                    nxt = ST_RAMP; tmr_load = 1'b1; tmr_val = ramp_m1;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // stage outputs
    always_comb begin
        en_ph1     = 1'b0;
        en_ph2     = 1'b0;
        en_wl      = 1'b0;
        resp_valid = 1'b0;
        ready      = 1'b0;
        unique case (state)
            ST_IDLE:  ready = 1'b1;
            ST_RAMP:  en_ph1 = 1'b1;
            ST_BOOST: begin en_ph1 = 1'b1; en_ph2 = 1'b1; end
            ST_SENSE: begin
                en_ph1 = 1'b1; en_ph2 = 1'b1; en_wl = 1'b1;
                resp_valid = tmr_done;
            end
            ST_DRAIN: ;
            default:  ready = 1'b0;
        endcase
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (state == ST_RAMP && row_q == $past(ch_row) && col_q == $past(ch_col)));

    assert_one_cycle_valid_R8: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (rst)
        (!ready && start) |=> ($stable(row_q) && $stable(col_q)));

    assert_ramp_after_drain_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RAMP && $past(state) != ST_RAMP)
            |-> ($past(state) == ST_IDLE || $past(state) == ST_DRAIN));

    assert_reset_idle_R12: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE));
endmodule

// File: rtl/row_gate_drv.sv
module row_gate_drv #(
    parameter int ROWS  = 16,
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ROW_W-1:0] row,
    input  logic             en_ph1,
    input  logic             en_ph2,
    input  logic             en_wl,
    output logic [ROWS-1:0]  sup1_n,
    output logic [ROWS-1:0]  sup2_n,
    output logic [ROWS-1:0]  wl
);
    for (genvar g = 0; g < ROWS; g++) begin : g_row
        logic hit;
        assign hit       = (row == ROW_W'(g));
        assign sup1_n[g] = !(hit && en_ph1);
        assign sup2_n[g] = !(hit && en_ph2);
        assign wl[g]     = hit && en_wl;

        assert_wl_needs_supply_R6: assert property (@(posedge clk) disable iff (rst)
            wl[g] |-> (!sup1_n[g] && !sup2_n[g]));

        assert_ph2_needs_ph1_R5: assert property (@(posedge clk) disable iff (rst)
            !sup2_n[g] |-> !sup1_n[g]);
    end

    assert_single_row_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~sup1_n) && $onehot0(wl));
endmodule

// File: rtl/word_mux.sv
module word_mux #(
    parameter int WORDS  = 16,
    parameter int WORD_W = 8,
    parameter int COL_W  = 4
) (
    input  logic [WORDS*WORD_W-1:0] row_bits,
    input  logic [COL_W-1:0]        col,
    output logic [WORD_W-1:0]       word
);
    logic [WORD_W-1:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign words[g] = row_bits[g*WORD_W +: WORD_W];
    end

    assign word = words[col];
endmodule

// File: rtl/pgate_row_seq.sv
module pgate_row_seq #(
    parameter int ROWS   = 16,
    parameter int WORDS  = 16,
    parameter int WORD_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  start,
    input  logic [$clog2(ROWS)+$clog2(WORDS)-1:0] challenge,
    input  logic [CNT_W-1:0]                      ramp_len,
    input  logic [CNT_W-1:0]                      boost_len,
    input  logic [CNT_W-1:0]                      sense_len,
    input  logic [CNT_W-1:0]                      drain_len,
    input  logic [CNT_W-1:0]                      repeat_len,
    input  logic [WORDS*WORD_W-1:0]               row_bits,
    output logic [ROWS-1:0]                       sup1_n,
    output logic [ROWS-1:0]                       sup2_n,
    output logic [ROWS-1:0]                       wl,
    output logic [$clog2(WORDS)-1:0]              col_sel,
    output logic [WORD_W-1:0]                     resp,
    output logic                                  resp_valid,
    output logic                                  ready
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(WORDS);

    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic [ROW_W-1:0] row_q;
    logic             en_ph1, en_ph2, en_wl;

    rowseq_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .ch_row     (challenge[ROW_W-1:0]),
        .ch_col     (challenge[ROW_W+COL_W-1:ROW_W]),
        .ramp_len   (ramp_len),
        .boost_len  (boost_len),
        .sense_len  (sense_len),
        .drain_len  (drain_len),
        .repeat_len (repeat_len),
        .tmr_done   (tmr_done),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .row_q      (row_q),
        .col_q      (col_sel),
        .en_ph1     (en_ph1),
        .en_ph2     (en_ph2),
        .en_wl      (en_wl),
        .resp_valid (resp_valid),
        .ready      (ready)
    );

    stage_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    row_gate_drv #(.ROWS(ROWS), .ROW_W(ROW_W)) u_drv (
        .clk    (clk),
        .rst    (rst),
        .row    (row_q),
        .en_ph1 (en_ph1),
        .en_ph2 (en_ph2),
        .en_wl  (en_wl),
        .sup1_n (sup1_n),
        .sup2_n (sup2_n),
        .wl     (wl)
    );

    word_mux #(.WORDS(WORDS), .WORD_W(WORD_W), .COL_W(COL_W)) u_mux (
        .row_bits (row_bits),
        .col      (col_sel),
        .word     (resp)
    );

    assert_valid_with_wl_R8: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (|wl));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        ready |-> ((&sup1_n) && (&sup2_n) && !(|wl)));
endmodule

// File: tb/tb_pgate_row_seq.sv
module tb_pgate_row_seq;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [7:0]   challenge = '0;
    logic [7:0]   ramp_len = '0, boost_len = '0, sense_len = '0, drain_len = '0, repeat_len = '0;
    logic [127:0] row_bits;
    logic [15:0]  sup1_n, sup2_n, wl;
    logic [3:0]   col_sel;
    logic [7:0]   resp;
    logic         resp_valid, ready;

    always #10 clk = ~clk;

    pgate_row_seq dut (
        .clk(clk), .rst(rst), .start(start), .challenge(challenge),
        .ramp_len(ramp_len), .boost_len(boost_len), .sense_len(sense_len),
        .drain_len(drain_len), .repeat_len(repeat_len), .row_bits(row_bits),
        .sup1_n(sup1_n), .sup2_n(sup2_n), .wl(wl), .col_sel(col_sel),
        .resp(resp), .resp_valid(resp_valid), .ready(ready)
    );

    // array model: a row's bits appear only while its word line is up
    logic [127:0] cells [16];
    always_comb begin
        row_bits = '0;
        for (int i = 0; i < 16; i++) if (wl[i]) row_bits = cells[i];
    end

    // reference model: per-cycle stage codes, 0 idle 1 ramp 2 boost 3 sense 5 sense-last 4 drain
    int     q[$];
    int     cur = 0;
    int     mrow = 0, mcol = 0;
    int     checks = 0, failures = 0, cyc = 0;
    bit     chk_en = 1'b0;
    string  scen = "R1";

    function automatic int eff(input logic [7:0] x);
        return (x == 0) ? 1 : int'(x);
    endfunction

    task automatic fill_runs();
        for (int r = 0; r < eff(repeat_len); r++) begin
            for (int k = 0; k < eff(ramp_len); k++)  q.push_back(1);
            for (int k = 0; k < eff(boost_len); k++) q.push_back(2);
            for (int k = 1; k < eff(sense_len); k++) q.push_back(3);
            q.push_back(5);
            for (int k = 0; k < eff(drain_len); k++) q.push_back(4);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            q.delete(); cur = 0; mrow = 0; mcol = 0;
        end else if (cur == 0 && start) begin
            mrow = int'(challenge[3:0]);
            mcol = int'(challenge[7:4]);
            fill_runs();
            cur = q.pop_front();
        end else if (q.size() > 0) begin
            cur = q.pop_front();
        end else begin
            cur = 0;
        end
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic string stage_req(input int c);
        case (c)
            0: return "R1";
            1: return "R4,R3";
            2: return "R5,R3";
            3: return "R6,R3";
            5: return "R6,R8,R3";
            default: return "R7,R3";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", req, scen, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en) begin
            logic [15:0] e1, e2, ew;
            e1 = '1; e2 = '1; ew = '0;
            if (cur == 1 || cur == 2 || cur == 3 || cur == 5) e1[mrow] = 1'b0;
            if (cur == 2 || cur == 3 || cur == 5)             e2[mrow] = 1'b0;
            if (cur == 3 || cur == 5)                         ew[mrow] = 1'b1;
            chk(stage_req(cur), 32'(sup1_n), 32'(e1));
            chk(stage_req(cur), 32'(sup2_n), 32'(e2));
            chk(stage_req(cur), 32'(wl), 32'(ew));
            chk("R8", 32'(resp_valid), 32'(cur == 5));
            chk("R1", 32'(ready), 32'(cur == 0));
            chk("R2", 32'(col_sel), 32'(mcol));
            if (cur == 5) chk("R8", 32'(resp), 32'(cells[mrow][mcol*8 +: 8]));
        end
    end

    task automatic kick(input logic [7:0] ch, input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] c, input logic [7:0] d, input logic [7:0] n);
        challenge = ch; ramp_len = a; boost_len = b; sense_len = c; drain_len = d; repeat_len = n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (cur != 0 || q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++)
            cells[i] = {$urandom(), $urandom(), $urandom(), $urandom()};
        repeat (2) @(negedge clk);
        chk_en = 1'b1;
        scen = "R1 reset";
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        scen = "R2 single evaluation";
        kick(8'h35, 8'd3, 8'd2, 8'd2, 8'd2, 8'd1);
        wait_idle();

        scen = "R4 R5 R6 R7 zero lengths clamp";
        kick(8'hF0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0);
        wait_idle();

        scen = "R10 three runs";
        kick(8'h0F, 8'd2, 8'd3, 8'd1, 8'd2, 8'd3);
        wait_idle();

        scen = "R9 start while busy";
        kick(8'h7A, 8'd4, 8'd3, 8'd3, 8'd2, 8'd1);
        repeat (2) @(negedge clk);
        challenge = 8'hA5; start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        wait_idle();

        scen = "R11 inputs changed mid-run";
        kick(8'h92, 8'd3, 8'd2, 8'd4, 8'd3, 8'd2);
        ramp_len = 8'd9; boost_len = 8'd1; sense_len = 8'd7; drain_len = 8'd0; repeat_len = 8'd5;
        wait_idle();

        scen = "R12 reset during sense";
        kick(8'h4C, 8'd2, 8'd2, 8'd6, 8'd2, 8'd2);
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        scen = "R2 start held high from idle";
        challenge = 8'hE1; ramp_len = 8'd1; boost_len = 8'd2; sense_len = 8'd2;
        drain_len = 8'd1; repeat_len = 8'd1;
        start = 1'b1;
        repeat (12) @(negedge clk);
        start = 1'b0;
        wait_idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule